// File: doc/BRIEF.md
# Programming Enable and Boundary Protect Controller

This block sits between the serial command front end of a small non-volatile memory and its programming engine. The front end presents one fully loaded command per pulse, together with the target word address and the levels of the two control pins. The pins are the program-enable level, sampled while the command was shifted in, and the protect-select level. The controller decides in one registered cycle whether the command may proceed. It answers with exactly one grant or abort pulse. An aborted erase or write never reaches a busy cycle.

Two pieces of state govern the decision. The first is an erase/write enable latch, which is disabled out of reset. The second is a boundary register that blocks every address at or above a stored value. The boundary register is loaded and cleared by its own command group, and a one-time freeze command locks it for good. Whole-array commands are refused while any boundary is active. The current boundary value, its active flag and the freeze flag are always visible, so the front end can shift them out on a protect-read command.

Top module: `prog_guard`

## Requirements
- R1: After reset, rsp_vld is low, bnd_active is 0, bnd_addr is all ones, bnd_frozen is 0, and the enable latch is disabled, so a WRITE is aborted.
- R2: Each cycle with cmd_vld high yields exactly one response in the next cycle, with rsp_vld high and exactly one of rsp_grant and rsp_abort high. No response appears in a cycle that follows one without cmd_vld.
- R3: EWEN (op 3) is granted and enables programming only when pe_lvl is 1 and pre_lvl is 0. EWDS (op 4, pre_lvl 0) disables programming and also ends the protect session.
- R4: READ (op 0) with pre_lvl 0 is granted whatever the enable latch and boundary state are.
- R5: WRITE (op 1) and ERASE (op 2) are granted only when pre_lvl is 0, the latch is enabled, and pe_lvl is 1. In addition, either bnd_active must be 0 or cmd_addr must be less than bnd_addr.
- R6: ERAL (op 5) and WRAL (op 6) are granted only when pre_lvl is 0, the latch is enabled, pe_lvl is 1, and bnd_active is 0.
- R7: Protect-group commands (ops 7 to 11) are aborted when pre_lvl is 0. Normal commands (ops 0 to 6) are aborted when pre_lvl is 1.
- R8: PREN (op 8) is granted with pre_lvl 1, pe_lvl 1 and the latch enabled, and it opens a protect session. PRWRITE (op 9), PRCLEAR (op 10) and PRDS (op 11) are also granted with pre_lvl 1, pe_lvl 1 and the latch enabled. They additionally need an open protect session and bnd_frozen at 0.
- R9: A granted PRWRITE loads bnd_addr with cmd_addr and sets bnd_active. A granted PRCLEAR sets bnd_addr to all ones and bnd_active to 0. Both changes are visible from the cycle after the command.
- R10: A granted PRDS sets bnd_frozen. From then on, PRWRITE, PRCLEAR and PRDS are aborted, and bnd_addr and bnd_active no longer change.
- R11: PRREAD (op 7) with pre_lvl 1 is granted and changes no state.
- R12: Opcodes 12 to 15 are always aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | One-cycle pulse: a fully loaded command is presented |
| cmd_op | input | 4 | Decoded command code |
| cmd_addr | input | ADDR_W | Target word address or new boundary value |
| pe_lvl | input | 1 | Program-enable pin level captured during loading |
| pre_lvl | input | 1 | Protect-select pin level |
| rsp_vld | output | 1 | Response pulse, one cycle after cmd_vld |
| rsp_grant | output | 1 | Command may proceed |
| rsp_abort | output | 1 | Command refused |
| bnd_addr | output | ADDR_W | Current protection boundary |
| bnd_active | output | 1 | Boundary is in force |
| bnd_frozen | output | 1 | Boundary permanently locked |

## Verification
Word writes and erases are issued at addresses just below the boundary, at the boundary and at the top address. These show whether the comparison is inclusive. Each gate is opened and closed one at a time: the pe level, the pre level, the enable latch and the protect session. This shows that each gate alone can refuse a command. The boundary is loaded, read, cleared and frozen in turn, and the bench checks the refused updates at the boundary outputs. Whole-array commands are tried with and without an active boundary.

// File: rtl/pg_pkg.sv
package pg_pkg;

   typedef enum logic [3:0] {
      OP_READ    = 4'd0,
      OP_WRITE   = 4'd1,
      OP_ERASE   = 4'd2,
      OP_EWEN    = 4'd3,
      OP_EWDS    = 4'd4,
      OP_ERAL    = 4'd5,
      OP_WRAL    = 4'd6,
      OP_PRREAD  = 4'd7,
      OP_PREN    = 4'd8,
      OP_PRWRITE = 4'd9,
      OP_PRCLEAR = 4'd10,
      OP_PRDS    = 4'd11
   } pg_op_e;

   localparam int OP_W = 4;

   // true for the protect command group
   function automatic logic is_prot_op(input logic [OP_W-1:0] op);
      return (op >= 4'd7) && (op <= 4'd11);
   endfunction

   // true for the normal command group
   function automatic logic is_norm_op(input logic [OP_W-1:0] op);
      return op <= 4'd6;
   endfunction

endpackage

// File: rtl/pg_wr_latch.sv
module pg_wr_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_en,
   input  logic clr_en,
   input  logic open_sess,
   output logic en_q,
   output logic sess_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         sess_q <= 1'b0;
      end else begin
         if (clr_en) begin
            en_q   <= 1'b0;
            sess_q <= 1'b0;
         end else begin
            if (set_en)    en_q   <= 1'b1;
            if (open_sess) sess_q <= 1'b1;
         end
      end
   end

   // R8
   sess_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sess_q |-> en_q);

   // R3
   en_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> $past(set_en));

   // R3
   en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> !en_q && !sess_q);

endmodule

// File: rtl/pg_bound_reg.sv
module pg_bound_reg #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic              freeze,
   input  logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] addr_q,
   output logic              active_q,
   output logic              frozen_q
);

   localparam logic [ADDR_W-1:0] NO_BOUND = {ADDR_W{1'b1}};

   logic upd_ok;
   assign upd_ok = !frozen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= NO_BOUND;
         active_q <= 1'b0;
         frozen_q <= 1'b0;
      end else if (upd_ok) begin
         if (load) begin
            addr_q   <= load_val;
            active_q <= 1'b1;
         end else if (clear) begin
            addr_q   <= NO_BOUND;
            active_q <= 1'b0;
         end
         if (freeze) frozen_q <= 1'b1;
      end
   end

   // R10
   frozen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frozen_q |=> frozen_q);

   // R10
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frozen_q |=> $stable(addr_q) && $stable(active_q));

   // R9
   idle_is_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> addr_q == NO_BOUND);

endmodule

// File: rtl/pg_bound_cmp.sv
module pg_bound_cmp #(
   parameter int ADDR_W   = 8,
   parameter int CMP_IMPL = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] bound,
   input  logic              active,
   output logic              hit
);

   logic at_or_above;

   generate
      if (CMP_IMPL == 0) begin : g_rel
         assign at_or_above = (addr >= bound);
      end else begin : g_sub
         logic [ADDR_W:0] diff;
         assign diff        = {1'b0, addr} - {1'b0, bound};
         assign at_or_above = !diff[ADDR_W];
      end
   endgenerate

   assign hit = active && at_or_above;

   initial begin
      cmp_impl_param_chk: assert (CMP_IMPL == 0 || CMP_IMPL == 1)
         else $error("pg_bound_cmp: CMP_IMPL must be 0 or 1");
   end

endmodule

// File: rtl/prog_guard.sv
module prog_guard #(
   parameter int ADDR_W   = 8,
   parameter int CMP_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  logic [3:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              pe_lvl,
   input  logic              pre_lvl,
   output logic              rsp_vld,
   output logic              rsp_grant,
   output logic              rsp_abort,
   output logic [ADDR_W-1:0] bnd_addr,
   output logic              bnd_active,
   output logic              bnd_frozen
);
   import pg_pkg::*;

   initial begin
      addr_w_param_chk: assert (ADDR_W >= 1 && ADDR_W <= 16)
         else $error("prog_guard: ADDR_W out of range");
   end

   logic   en_q, sess_q, hit;
   logic   ok;
   pg_op_e op;
   logic   set_en, clr_en, open_sess, ld_bnd, clr_bnd, frz_bnd;
   logic   norm_gate, prot_gate, prog_gate, bnd_upd_gate;

   assign op = pg_op_e'(cmd_op);

   pg_bound_cmp #(.ADDR_W(ADDR_W), .CMP_IMPL(CMP_IMPL)) u_cmp (
      .addr   (cmd_addr),
      .bound  (bnd_addr),
      .active (bnd_active),
      .hit    (hit)
   );

   assign norm_gate    = !pre_lvl;
   assign prot_gate    = pre_lvl;
   assign prog_gate    = en_q && pe_lvl;
   assign bnd_upd_gate = prot_gate && prog_gate && sess_q && !bnd_frozen;

   always_comb begin
      ok = 1'b0;
      case (op)
         OP_READ:    ok = norm_gate;
         OP_WRITE,
         OP_ERASE:   ok = norm_gate && prog_gate && !hit;
         OP_ERAL,
         OP_WRAL:    ok = norm_gate && prog_gate && !bnd_active;
         OP_EWEN:    ok = norm_gate && pe_lvl;
         OP_EWDS:    ok = norm_gate;
         OP_PRREAD:  ok = prot_gate;
         OP_PREN:    ok = prot_gate && prog_gate;
         OP_PRWRITE,
         OP_PRCLEAR,
         OP_PRDS:    ok = bnd_upd_gate;
         default:    ok = 1'b0;
      endcase
   end

   assign set_en    = cmd_vld && ok && (op == OP_EWEN);
   assign clr_en    = cmd_vld && ok && (op == OP_EWDS);
   assign open_sess = cmd_vld && ok && (op == OP_PREN);
   assign ld_bnd    = cmd_vld && ok && (op == OP_PRWRITE);
   assign clr_bnd   = cmd_vld && ok && (op == OP_PRCLEAR);
   assign frz_bnd   = cmd_vld && ok && (op == OP_PRDS);

   pg_wr_latch u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (set_en),
      .clr_en    (clr_en),
      .open_sess (open_sess),
      .en_q      (en_q),
      .sess_q    (sess_q)
   );

   pg_bound_reg #(.ADDR_W(ADDR_W)) u_bound (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_bnd),
      .clear    (clr_bnd),
      .freeze   (frz_bnd),
      .load_val (cmd_addr),
      .addr_q   (bnd_addr),
      .active_q (bnd_active),
      .frozen_q (bnd_frozen)
   );

   logic rsp_vld_q, rsp_ok_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld_q <= 1'b0;
         rsp_ok_q  <= 1'b0;
      end else begin
         rsp_vld_q <= cmd_vld;
         rsp_ok_q  <= cmd_vld && ok;
      end
   end

   assign rsp_vld   = rsp_vld_q;
   assign rsp_grant = rsp_vld_q && rsp_ok_q;
   assign rsp_abort = rsp_vld_q && !rsp_ok_q;

   // R2
   rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |=> rsp_vld);

   // R2
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_vld |=> !rsp_vld && !rsp_grant && !rsp_abort);

   // R5
   word_prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && (op == OP_WRITE || op == OP_ERASE))
      |=> rsp_grant |-> ($past(en_q) && $past(pe_lvl) && !$past(pre_lvl)));

   // R6
   whole_array_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && (op == OP_ERAL || op == OP_WRAL) && bnd_active) |=> rsp_abort);

   // R7
   group_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && is_prot_op(cmd_op) && !pre_lvl) |=> rsp_abort);

   // R12
   bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_op >= 4'd12) |=> rsp_abort);

endmodule

// File: tb/prog_guard_tb.sv
module prog_guard_tb;

   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_vld = 1'b0;
   logic [3:0]    cmd_op = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic          pe_lvl = 1'b0;
   logic          pre_lvl = 1'b0;
   logic          rsp_vld, rsp_grant, rsp_abort;
   logic [AW-1:0] bnd_addr;
   logic          bnd_active, bnd_frozen;

   always #10 clk = ~clk;

   prog_guard #(.ADDR_W(AW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_vld    (cmd_vld),
      .cmd_op     (cmd_op),
      .cmd_addr   (cmd_addr),
      .pe_lvl     (pe_lvl),
      .pre_lvl    (pre_lvl),
      .rsp_vld    (rsp_vld),
      .rsp_grant  (rsp_grant),
      .rsp_abort  (rsp_abort),
      .bnd_addr   (bnd_addr),
      .bnd_active (bnd_active),
      .bnd_frozen (bnd_frozen)
   );

   typedef struct {
      bit    grant;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;

   task automatic check(input bit cond, input string req,
                        input longint act, input longint expv);
      n_tests++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // driver: present one command and push the expected answer
   task automatic issue(input int op, input int addr, input bit pe,
                        input bit pre, input bit exp_g, input string req);
      exp_t e;
      @(negedge clk);
      e.grant = exp_g;
      e.req   = req;
      exp_q.push_back(e);
      cmd_vld  = 1'b1;
      cmd_op   = 4'(op);
      cmd_addr = AW'(addr);
      pe_lvl   = pe;
      pre_lvl  = pre;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmd_vld = 1'b0;
         pe_lvl  = 1'b0;
      end
   endtask

   task automatic check_bnd(input int a, input bit act, input bit frz,
                            input string req);
      check(bnd_addr == AW'(a), req, bnd_addr, a);
      check(bnd_active == act, req, bnd_active, act);
      check(bnd_frozen == frz, req, bnd_frozen, frz);
   endtask

   // monitor: pop and compare each response (R2)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rsp_vld) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2 unexpected response", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(rsp_grant == e.grant, e.req, rsp_grant, e.grant);
               check(rsp_abort == !e.grant, {e.req, " (R2 abort)"}, rsp_abort, !e.grant);
            end
         end else begin
            check(!rsp_grant && !rsp_abort, "R2 idle outputs", {rsp_grant, rsp_abort}, 0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(rsp_vld == 1'b0, "R1 rsp_vld", rsp_vld, 0);
      check_bnd(8'hFF, 1'b0, 1'b0, "R1 boundary");
      issue(1, 8'h10, 1, 0, 0, "R1 write before enable");
      issue(0, 8'h10, 0, 0, 1, "R4 read while disabled");
      issue(3, 0, 0, 0, 0, "R3 ewen pe low");
      issue(1, 8'h10, 1, 0, 0, "R3 write after failed ewen");
      issue(3, 0, 1, 1, 0, "R7 ewen with pre high");
      issue(3, 0, 1, 0, 1, "R3 ewen");
      issue(1, 8'h10, 0, 0, 0, "R5 write pe low");
      issue(1, 8'hFF, 1, 1, 0, "R7 write pre high");
      issue(1, 8'hFF, 1, 0, 1, "R5 write top no bound");
      issue(2, 8'h05, 1, 0, 1, "R5 erase no bound");
      issue(5, 0, 1, 0, 1, "R6 eral no bound");
      issue(6, 0, 1, 0, 1, "R6 wral no bound");
      issue(6, 0, 0, 0, 0, "R6 wral pe low");
      issue(8, 0, 1, 0, 0, "R7 pren pre low");
      issue(9, 8'h80, 1, 1, 0, "R8 prwrite without session");
      issue(8, 0, 0, 1, 0, "R8 pren pe low");
      issue(8, 0, 1, 1, 1, "R8 pren");
      issue(9, 8'h80, 1, 1, 1, "R9 prwrite 80");
      idle(2);
      check_bnd(8'h80, 1'b1, 1'b0, "R9 loaded");
      issue(1, 8'h7F, 1, 0, 1, "R5 write below bound");
      issue(1, 8'h80, 1, 0, 0, "R5 write at bound");
      issue(1, 8'hFF, 1, 0, 0, "R5 write top");
      issue(2, 8'h80, 1, 0, 0, "R5 erase at bound");
      issue(2, 8'h00, 1, 0, 1, "R5 erase zero");
      issue(6, 0, 1, 0, 0, "R6 wral with bound");
      issue(5, 0, 1, 0, 0, "R6 eral with bound");
      issue(0, 8'h90, 0, 0, 1, "R4 read above bound");
      issue(7, 0, 0, 1, 1, "R11 prread");
      issue(7, 0, 0, 0, 0, "R7 prread pre low");
      idle(2);
      check_bnd(8'h80, 1'b1, 1'b0, "R11 no change");
      issue(10, 0, 1, 1, 1, "R9 prclear");
      idle(2);
      check_bnd(8'hFF, 1'b0, 1'b0, "R9 cleared");
      issue(6, 0, 1, 0, 1, "R6 wral after clear");
      issue(4, 0, 0, 0, 1, "R3 ewds");
      issue(1, 8'h01, 1, 0, 0, "R3 write after ewds");
      issue(3, 0, 1, 0, 1, "R3 ewen again");
      issue(9, 8'h20, 1, 1, 0, "R3 session ended by ewds");
      idle(2);
      check_bnd(8'hFF, 1'b0, 1'b0, "R3 bound untouched");
      issue(8, 0, 1, 1, 1, "R8 pren again");
      issue(9, 8'h40, 1, 1, 1, "R9 prwrite 40");
      issue(11, 0, 1, 1, 1, "R10 prds");
      idle(2);
      check_bnd(8'h40, 1'b1, 1'b1, "R10 frozen");
      issue(10, 0, 1, 1, 0, "R10 prclear after freeze");
      issue(9, 8'h10, 1, 1, 0, "R10 prwrite after freeze");
      issue(11, 0, 1, 1, 0, "R10 prds again");
      idle(2);
      check_bnd(8'h40, 1'b1, 1'b1, "R10 bound held");
      issue(1, 8'h3F, 1, 0, 1, "R5 write below frozen bound");
      issue(1, 8'h40, 1, 0, 0, "R5 write at frozen bound");
      issue(12, 0, 1, 0, 0, "R12 op 12");
      issue(15, 0, 1, 1, 0, "R12 op 15");
      idle(3);
      check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule